// File: doc/BRIEF.md
# Byte-Serial ModRM Instruction Field Extractor

This block is the front end of an instruction decoder. It takes an instruction stream one byte per valid/ready handshake. It walks through the encoding of the immediate-group opcode 80h: optional prefixes, the opcode, the ModRM byte, an optional SIB byte, a displacement of zero to four bytes and a closing 8-bit immediate. When the immediate byte arrives, the block reports every extracted field and the total byte count for one cycle. The caller keeps feeding bytes. The block accepts a byte on every cycle after reset, so instructions can follow one another with no gap.

The layout of the memory-operand bytes depends on the effective address size. That size starts from the static code-mode input and is toggled by the address-size prefix 67h, so the same byte string can have a different length in a different mode. The operand-size prefix 66h is consumed and counted, but it does not change an 8-bit operation. Any other leading byte ends the attempt with an unsupported flag, and the block then waits for a new instruction.

Top module: `modrm_parser`

## Requirements
- R1: While reset is low, and for the first clock edge after it rises, `byte_ready_o`, `done_o` and `unsup_o` are 0. From the second edge after release onward, `byte_ready_o` is 1.
- R2: The code mode and the address size both use the encoding 0 = 16-bit, 1 = 32-bit, 2 = 64-bit. With no 67h prefix, the address size equals the mode. With 67h, mode 0 gives 1, mode 1 gives 0 and mode 2 gives 1. `asize_o` reports the result.
- R3: With 16-bit addressing there is never a SIB byte. mod=01 takes one displacement byte. mod=10 takes two. mod=00 with rm=110 takes two. Every other mod=00 form takes none.
- R4: With 32- or 64-bit addressing, rm=100 with mod other than 11 means a SIB byte follows the ModRM byte. mod=01 takes one displacement byte. mod=10 takes four. mod=00 with rm=101 takes four.
- R5: The SIB fields are scale = bits 7:6, index = bits 5:3 and base = bits 2:0. When mod=00 and base=101, four displacement bytes follow the SIB byte. With no SIB byte, scale, index and base read 0.
- R6: mod=11 is a register operand with no SIB and no displacement. A 67h prefix changes nothing about it except adding one to the length.
- R7: Each 66h byte is accepted, counted in the length and otherwise ignored.
- R8: `done_o` is high for exactly the one cycle after the immediate byte is accepted. In that cycle: mod, reg and rm are ModRM bits 7:6, 5:3 and 2:0. `disp_o` holds the displacement bytes little-endian and zero-extended. `imm_o` holds the immediate. `len_o` counts every accepted byte of the instruction, prefixes included.
- R9: A leading byte that is neither 80h, 66h nor 67h raises `unsup_o` for one cycle and never `done_o`. The next byte is then treated as the start of a new instruction.
- R10: Up to `MAX_PFX` (default 4) prefix bytes are accepted. One more prefix byte is handled as in R9.
- R11: A cycle without a handshake changes no parse state and raises neither `done_o` nor `unsup_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | Static code mode: 0 = 16-bit, 1 = 32-bit, 2 = 64-bit |
| byte_valid_i | input | 1 | A stream byte is offered |
| byte_data_i | input | 8 | Stream byte |
| byte_ready_o | output | 1 | Block accepts a byte this cycle |
| done_o | output | 1 | One-cycle pulse: instruction complete, fields valid |
| unsup_o | output | 1 | One-cycle pulse: unsupported leading byte or too many prefixes |
| mod_o | output | 2 | ModRM mod field |
| reg_o | output | 3 | ModRM reg field (2 selects add-with-carry) |
| rm_o | output | 3 | ModRM rm field |
| has_sib_o | output | 1 | A SIB byte was present |
| scale_o | output | 2 | SIB scale field |
| index_o | output | 3 | SIB index field |
| base_o | output | 3 | SIB base field |
| disp_o | output | 32 | Displacement, little-endian, zero-extended |
| imm_o | output | 8 | 8-bit immediate |
| asize_o | output | 2 | Effective address size, same encoding as `mode_i` |
| len_o | output | LEN_W (4) | Total instruction length in bytes |

## Verification
Suppose a wrong address-size latch, a wrong SIB decision or a wrong displacement count leaves the state machine off by one or more bytes. Then the immediate slot receives the wrong byte, and the `done_o` pulse of that same instruction comes early or late, with a wrong `len_o` and `imm_o`. Suppose instead the machine ends up out of step with the stream. The next instruction's first byte is then read as something else, and `unsup_o` or a wrong `len_o` appears within that next instruction. A prefix flag that fails to clear shows up as a wrong `asize_o` on the following instruction.

// File: rtl/mp_pkg.sv
package mp_pkg;
  typedef enum logic [1:0] {SZ16 = 2'd0, SZ32 = 2'd1, SZ64 = 2'd2} asz_e;
  typedef enum logic [2:0] {ST_LEAD, ST_MODRM, ST_SIB, ST_DISP, ST_IMM} st_e;

  localparam logic [7:0] OP_GRP1  = 8'h80;
  localparam logic [7:0] PFX_ASZ  = 8'h67;
  localparam logic [7:0] PFX_OSZ  = 8'h66;

  localparam int DISP_MAX = 4;
  localparam int DISP_W   = 8 * DISP_MAX;
  localparam int DIDX_W   = $clog2(DISP_MAX);
  localparam int DLEN_W   = $clog2(DISP_MAX + 1);
endpackage

// File: rtl/mp_rst_sync.sv
module mp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_n;

  always_comb sh_n = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sh_q <= '0;
    else          sh_q <= sh_n;
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/mp_asize.sv
module mp_asize
  import mp_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       flip_i,
  output asz_e       asize_o
);
  always_comb begin
    case (mode_i)
      2'd1:    asize_o = flip_i ? SZ16 : SZ32;
      2'd2:    asize_o = flip_i ? SZ32 : SZ64;
      default: asize_o = flip_i ? SZ32 : SZ16;
    endcase
  end
endmodule

// File: rtl/mp_layout.sv
module mp_layout
  import mp_pkg::*;
(
  input  asz_e              asize_i,
  input  logic [1:0]        mod_i,
  input  logic [2:0]        rm_i,
  input  logic [2:0]        sib_base_i,
  output logic              sib_follows_o,
  output logic [DLEN_W-1:0] dlen_modrm_o,
  output logic [DLEN_W-1:0] dlen_sib_o
);
  localparam logic [DLEN_W-1:0] L0 = DLEN_W'(0);
  localparam logic [DLEN_W-1:0] L1 = DLEN_W'(1);
  localparam logic [DLEN_W-1:0] L2 = DLEN_W'(2);
  localparam logic [DLEN_W-1:0] L4 = DLEN_W'(DISP_MAX);

  logic wide;
  assign wide = (asize_i != SZ16);

  always_comb begin
    sib_follows_o = 1'b0;
    dlen_modrm_o  = L0;
    if (!wide) begin
      case (mod_i)
        2'b01:   dlen_modrm_o = L1;
        2'b10:   dlen_modrm_o = L2;
        2'b00:   dlen_modrm_o = (rm_i == 3'b110) ? L2 : L0;
        default: dlen_modrm_o = L0;
      endcase
    end else begin
      sib_follows_o = (mod_i != 2'b11) && (rm_i == 3'b100);
      case (mod_i)
        2'b01:   dlen_modrm_o = L1;
        2'b10:   dlen_modrm_o = L4;
        2'b00:   dlen_modrm_o = (rm_i == 3'b101) ? L4 : L0;
        default: dlen_modrm_o = L0;
      endcase
    end
    dlen_sib_o = ((mod_i == 2'b00) && (sib_base_i == 3'b101)) ? L4 : dlen_modrm_o;
  end
endmodule

// File: rtl/modrm_parser.sv
module modrm_parser
  import mp_pkg::*;
#(
  parameter int MAX_PFX = 4,
  parameter int LEN_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_data_i,
  output logic              byte_ready_o,
  output logic              done_o,
  output logic              unsup_o,
  output logic [1:0]        mod_o,
  output logic [2:0]        reg_o,
  output logic [2:0]        rm_o,
  output logic              has_sib_o,
  output logic [1:0]        scale_o,
  output logic [2:0]        index_o,
  output logic [2:0]        base_o,
  output logic [DISP_W-1:0] disp_o,
  output logic [7:0]        imm_o,
  output logic [1:0]        asize_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam int PCNT_W = $clog2(MAX_PFX + 1);

  logic rst_ok, accept;
  st_e  st_q, st_n;
  logic flip_q, flip_n;
  logic [PCNT_W-1:0] pcnt_q, pcnt_n;
  logic [LEN_W-1:0]  cnt_q, cnt_n, len_q, len_n;
  asz_e asz_q, asz_n, asz_cur;
  logic [7:0] modrm_q, modrm_n, sib_q, sib_n, imm_q, imm_n;
  logic       has_sib_q, has_sib_n;
  logic [DISP_W-1:0] disp_q, disp_n;
  logic [DLEN_W-1:0] dleft_q, dleft_n;
  logic [DIDX_W-1:0] didx_q, didx_n;
  logic done_q, done_n, unsup_q, unsup_n;
  logic [7:0] modrm_sel;
  logic sib_follows;
  logic [DLEN_W-1:0] dlen_modrm, dlen_sib;

  mp_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_ok));

  assign byte_ready_o = rst_ok;
  assign accept       = byte_valid_i & byte_ready_o;

  mp_asize u_asz (.mode_i(mode_i), .flip_i(flip_q), .asize_o(asz_cur));

  assign modrm_sel = (st_q == ST_MODRM) ? byte_data_i : modrm_q;

  mp_layout u_lay (
    .asize_i      (asz_q),
    .mod_i        (modrm_sel[7:6]),
    .rm_i         (modrm_sel[2:0]),
    .sib_base_i   (byte_data_i[2:0]),
    .sib_follows_o(sib_follows),
    .dlen_modrm_o (dlen_modrm),
    .dlen_sib_o   (dlen_sib)
  );

  always_comb begin
    st_n      = st_q;
    flip_n    = flip_q;
    pcnt_n    = pcnt_q;
    cnt_n     = cnt_q + LEN_W'(1);
    len_n     = len_q;
    asz_n     = asz_q;
    modrm_n   = modrm_q;
    sib_n     = sib_q;
    has_sib_n = has_sib_q;
    disp_n    = disp_q;
    dleft_n   = dleft_q;
    didx_n    = didx_q;
    imm_n     = imm_q;
    done_n    = 1'b0;
    unsup_n   = 1'b0;
    case (st_q)
      ST_LEAD: begin
        if (byte_data_i == PFX_ASZ || byte_data_i == PFX_OSZ) begin
          if (pcnt_q == PCNT_W'(MAX_PFX)) begin
            unsup_n = 1'b1;
            flip_n  = 1'b0;
            pcnt_n  = '0;
            cnt_n   = '0;
          end else begin
            pcnt_n = pcnt_q + PCNT_W'(1);
            if (byte_data_i == PFX_ASZ) flip_n = 1'b1;
          end
        end else if (byte_data_i == OP_GRP1) begin
          st_n      = ST_MODRM;
          asz_n     = asz_cur;
          sib_n     = '0;
          has_sib_n = 1'b0;
          disp_n    = '0;
        end else begin
          unsup_n = 1'b1;
          flip_n  = 1'b0;
          pcnt_n  = '0;
          cnt_n   = '0;
        end
      end
      ST_MODRM: begin
        modrm_n = byte_data_i;
        didx_n  = '0;
        dleft_n = dlen_modrm;
        if (sib_follows) begin
          st_n      = ST_SIB;
          has_sib_n = 1'b1;
        end else if (dlen_modrm != '0) begin
          st_n = ST_DISP;
        end else begin
          st_n = ST_IMM;
        end
      end
      ST_SIB: begin
        sib_n   = byte_data_i;
        dleft_n = dlen_sib;
        st_n    = (dlen_sib != '0) ? ST_DISP : ST_IMM;
      end
      ST_DISP: begin
        disp_n[{didx_q, 3'b000} +: 8] = byte_data_i;
        didx_n  = didx_q + DIDX_W'(1);
        dleft_n = dleft_q - DLEN_W'(1);
        if (dleft_q == DLEN_W'(1)) st_n = ST_IMM;
      end
      ST_IMM: begin
        imm_n  = byte_data_i;
        len_n  = cnt_q + LEN_W'(1);
        done_n = 1'b1;
        st_n   = ST_LEAD;
        cnt_n  = '0;
        pcnt_n = '0;
        flip_n = 1'b0;
      end
      default: begin
        st_n   = ST_LEAD;
        cnt_n  = '0;
        pcnt_n = '0;
        flip_n = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      st_q      <= ST_LEAD;
      flip_q    <= 1'b0;
      pcnt_q    <= '0;
      cnt_q     <= '0;
      len_q     <= '0;
      asz_q     <= SZ16;
      modrm_q   <= '0;
      sib_q     <= '0;
      has_sib_q <= 1'b0;
      disp_q    <= '0;
      dleft_q   <= '0;
      didx_q    <= '0;
      imm_q     <= '0;
      done_q    <= 1'b0;
      unsup_q   <= 1'b0;
    end else begin
      done_q  <= accept & done_n;
      unsup_q <= accept & unsup_n;
      if (accept) begin
        st_q      <= st_n;
        flip_q    <= flip_n;
        pcnt_q    <= pcnt_n;
        cnt_q     <= cnt_n;
        len_q     <= len_n;
        asz_q     <= asz_n;
        modrm_q   <= modrm_n;
        sib_q     <= sib_n;
        has_sib_q <= has_sib_n;
        disp_q    <= disp_n;
        dleft_q   <= dleft_n;
        didx_q    <= didx_n;
        imm_q     <= imm_n;
      end
    end
  end

  assign done_o    = done_q;
  assign unsup_o   = unsup_q;
  assign mod_o     = modrm_q[7:6];
  assign reg_o     = modrm_q[5:3];
  assign rm_o      = modrm_q[2:0];
  assign has_sib_o = has_sib_q;
  assign scale_o   = sib_q[7:6];
  assign index_o   = sib_q[5:3];
  assign base_o    = sib_q[2:0];
  assign disp_o    = disp_q;
  assign imm_o     = imm_q;
  assign asize_o   = asz_q;
  assign len_o     = len_q;
endmodule

// File: rtl/mp_checker.sv
module mp_checker #(
  parameter int LEN_W  = 4,
  parameter int DISP_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_valid_i,
  input logic              byte_ready_o,
  input logic              done_o,
  input logic              unsup_o,
  input logic [1:0]        mod_o,
  input logic              has_sib_o,
  input logic [DISP_W-1:0] disp_o,
  input logic [1:0]        asize_o,
  input logic [LEN_W-1:0]  len_o
);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r9_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && unsup_o));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_valid_i && byte_ready_o) |=> (!done_o && !unsup_o));

  a_r6_reg_form: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && mod_o == 2'b11) |-> (!has_sib_o && disp_o == '0));

  a_r3_no_sib16: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && asize_o == 2'd0) |-> !has_sib_o);

  a_r8_len_min: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (len_o >= LEN_W'(3)));

  a_r1_quiet_unready: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_ready_o |-> (!done_o && !unsup_o));
endmodule

bind modrm_parser mp_checker #(.LEN_W(LEN_W), .DISP_W(mp_pkg::DISP_W)) u_chk (.*);

// File: tb/tb_modrm_parser.sv
module tb_modrm_parser;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  typedef struct packed {
    logic [1:0]  mode;
    logic [3:0]  nb;
    logic [95:0] bytes;
    logic        unsup;
    logic [3:0]  len;
    logic [1:0]  asz;
    logic [1:0]  md;
    logic [2:0]  rg;
    logic [2:0]  rm;
    logic        sib;
    logic [7:0]  sibv;
    logic [31:0] disp;
    logic [7:0]  imm;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 4'd3, 96'h071080,           1'b0, 4'd3, 2'd0, 2'd0, 3'd2, 3'd0, 1'b0, 8'h00, 32'h0,        8'h07},
    '{2'd0, 4'd4, 96'h07108067,         1'b0, 4'd4, 2'd1, 2'd0, 3'd2, 3'd0, 1'b0, 8'h00, 32'h0,        8'h07},
    '{2'd1, 4'd3, 96'h071080,           1'b0, 4'd3, 2'd1, 2'd0, 3'd2, 3'd0, 1'b0, 8'h00, 32'h0,        8'h07},
    '{2'd1, 4'd4, 96'h07108067,         1'b0, 4'd4, 2'd0, 2'd0, 3'd2, 3'd0, 1'b0, 8'h00, 32'h0,        8'h07},
    '{2'd2, 4'd3, 96'h071080,           1'b0, 4'd3, 2'd2, 2'd0, 3'd2, 3'd0, 1'b0, 8'h00, 32'h0,        8'h07},
    '{2'd2, 4'd4, 96'h07108067,         1'b0, 4'd4, 2'd1, 2'd0, 3'd2, 3'd0, 1'b0, 8'h00, 32'h0,        8'h07},
    '{2'd0, 4'd3, 96'h07D480,           1'b0, 4'd3, 2'd0, 2'd3, 3'd2, 3'd4, 1'b0, 8'h00, 32'h0,        8'h07},
    '{2'd0, 4'd4, 96'h07D48067,         1'b0, 4'd4, 2'd1, 2'd3, 3'd2, 3'd4, 1'b0, 8'h00, 32'h0,        8'h07},
    '{2'd0, 4'd5, 96'h0512341680,       1'b0, 4'd5, 2'd0, 2'd0, 3'd2, 3'd6, 1'b0, 8'h00, 32'h1234,     8'h05},
    '{2'd0, 4'd4, 96'h09F05080,         1'b0, 4'd4, 2'd0, 2'd1, 3'd2, 3'd0, 1'b0, 8'h00, 32'hF0,       8'h09},
    '{2'd0, 4'd5, 96'h0912349080,       1'b0, 4'd5, 2'd0, 2'd2, 3'd2, 3'd0, 1'b0, 8'h00, 32'h1234,     8'h09},
    '{2'd1, 4'd4, 96'h07881480,         1'b0, 4'd4, 2'd1, 2'd0, 3'd2, 3'd4, 1'b1, 8'h88, 32'h0,        8'h07},
    '{2'd1, 4'd8, 96'h0312345678251480, 1'b0, 4'd8, 2'd1, 2'd0, 3'd2, 3'd4, 1'b1, 8'h25, 32'h12345678, 8'h03},
    '{2'd1, 4'd5, 96'h0310255480,       1'b0, 4'd5, 2'd1, 2'd1, 3'd2, 3'd4, 1'b1, 8'h25, 32'h10,       8'h03},
    '{2'd1, 4'd7, 96'h02123456781580,   1'b0, 4'd7, 2'd1, 2'd0, 3'd2, 3'd5, 1'b0, 8'h00, 32'h12345678, 8'h02},
    '{2'd1, 4'd8, 96'h0111223344249480, 1'b0, 4'd8, 2'd1, 2'd2, 3'd2, 3'd4, 1'b1, 8'h24, 32'h11223344, 8'h01},
    '{2'd1, 4'd4, 96'h07108066,         1'b0, 4'd4, 2'd1, 2'd0, 3'd2, 3'd0, 1'b0, 8'h00, 32'h0,        8'h07},
    '{2'd0, 4'd7, 96'h06082054806766,   1'b0, 4'd7, 2'd1, 2'd1, 3'd2, 3'd4, 1'b1, 8'h20, 32'h08,       8'h06},
    '{2'd0, 4'd1, 96'h0F,               1'b1, 4'd0, 2'd0, 2'd0, 3'd0, 3'd0, 1'b0, 8'h00, 32'h0,        8'h00},
    '{2'd1, 4'd2, 96'h9067,             1'b1, 4'd0, 2'd0, 2'd0, 3'd0, 3'd0, 1'b0, 8'h00, 32'h0,        8'h00},
    '{2'd0, 4'd4, 96'h07068067,         1'b0, 4'd4, 2'd1, 2'd0, 3'd0, 3'd6, 1'b0, 8'h00, 32'h0,        8'h07},
    '{2'd1, 4'd6, 96'h071234068067,     1'b0, 4'd6, 2'd0, 2'd0, 3'd0, 3'd6, 1'b0, 8'h00, 32'h1234,     8'h07},
    '{2'd2, 4'd5, 96'h11F8244480,       1'b0, 4'd5, 2'd2, 2'd1, 3'd0, 3'd4, 1'b1, 8'h24, 32'hF8,       8'h11}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] mode;
  logic byte_valid;
  logic [7:0] byte_data;
  logic byte_ready, done, unsup, has_sib;
  logic [1:0] mod_w, scale, asize;
  logic [2:0] reg_w, rm_w, index, base_w;
  logic [31:0] disp;
  logic [7:0] imm;
  logic [3:0] len;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modrm_parser dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .byte_valid_i(byte_valid), .byte_data_i(byte_data), .byte_ready_o(byte_ready),
    .done_o(done), .unsup_o(unsup), .mod_o(mod_w), .reg_o(reg_w), .rm_o(rm_w),
    .has_sib_o(has_sib), .scale_o(scale), .index_o(index), .base_o(base_w),
    .disp_o(disp), .imm_o(imm), .asize_o(asize), .len_o(len)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic string vtag(input int k);
    if (k <= 5 || k == 20 || k == 21) return "R2";
    if (k <= 7)  return "R6";
    if (k <= 10) return "R3";
    if (k == 12) return "R5";
    if (k <= 15 || k == 22) return "R4";
    if (k <= 17) return "R7";
    return "R9";
  endfunction

  // Starts and ends at a falling edge; valid stays high after the last byte.
  task automatic send_instr(input logic [95:0] b, input int nb, input int gap, input string tag);
    logic early = 1'b0;
    for (int i = 0; i < nb; i++) begin
      byte_valid = 1'b1;
      byte_data  = b[8*i +: 8];
      @(posedge clk);
      @(negedge clk);
      if (i < nb - 1) begin
        if (done || unsup) early = 1'b1;
        if (gap > 0) begin
          byte_valid = 1'b0;
          for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            if (done || unsup) early = 1'b1;
          end
        end
      end
    end
    chk({tag, " no completion before final byte"}, early, 0);
  endtask

  task automatic check_vec(input vec_t v, input string tag);
    if (v.unsup) begin
      chk({tag, " unsup flag"}, unsup, 1);
      chk({tag, " no done on unsup"}, done, 0);
    end else begin
      chk({tag, " done R8"}, done, 1);
      chk({tag, " unsup low"}, unsup, 0);
      chk({tag, " len"}, len, v.len);
      chk({tag, " asize"}, asize, v.asz);
      chk({tag, " mod/reg/rm"}, {mod_w, reg_w, rm_w}, {v.md, v.rg, v.rm});
      chk({tag, " has_sib"}, has_sib, v.sib);
      chk({tag, " sib fields"}, {scale, index, base_w}, v.sibv);
      chk({tag, " disp"}, disp, v.disp);
      chk({tag, " imm"}, imm, v.imm);
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R11 watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    mode = 2'd0;
    byte_valid = 1'b0;
    byte_data = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", byte_ready, 0);
    chk("R1 done in reset", done, 0);
    chk("R1 unsup in reset", unsup, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready one edge after release", byte_ready, 0);
    @(negedge clk);
    chk("R1 ready two edges after release", byte_ready, 1);

    for (int k = 0; k < NV; k++) begin
      mode = VEC[k].mode;
      @(negedge clk);
      send_instr(VEC[k].bytes, int'(VEC[k].nb), 0, vtag(k));
      check_vec(VEC[k], vtag(k));
      byte_valid = 1'b0;
    end

    // R11: gaps between bytes change nothing
    mode = 2'd1;
    @(negedge clk);
    send_instr(VEC[12].bytes, int'(VEC[12].nb), 2, "R11");
    check_vec(VEC[12], "R11");
    byte_valid = 1'b0;
    @(negedge clk);
    chk("R11 done drops while idle", done, 0);

    // R10: four prefixes accepted, a fifth rejected
    mode = 2'd0;
    @(negedge clk);
    send_instr(96'h07108066676666, 7, 0, "R10");
    chk("R10 four prefixes done", done, 1);
    chk("R10 four prefixes len", len, 7);
    chk("R10 four prefixes asize", asize, 1);
    send_instr(96'h6666666666, 5, 0, "R10");
    chk("R10 fifth prefix unsup", unsup, 1);
    byte_valid = 1'b0;

    // R8: back-to-back instructions, one-cycle done each
    @(negedge clk);
    send_instr(96'h071080, 3, 0, "R8");
    chk("R8 first done", done, 1);
    chk("R8 first len", len, 3);
    send_instr(96'h09F05080, 4, 0, "R8");
    chk("R8 second done", done, 1);
    chk("R8 second disp", disp, 32'hF0);
    chk("R8 second len", len, 4);

    // R9: recovery straight after an unsupported byte
    send_instr(96'h0F, 1, 0, "R9");
    chk("R9 unsup", unsup, 1);
    send_instr(96'h071080, 3, 0, "R9");
    chk("R9 recovered done", done, 1);
    chk("R9 recovered len", len, 3);
    chk("R9 recovered asize", asize, 0);
    byte_valid = 1'b0;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule